// File: doc/BRIEF.md
# Flash Configuration Register Reset Unit

This block keeps the configuration state that a serial flash command engine consults while it runs: a 16-bit persistent configuration word, an 8-bit run-time configuration byte, an 8-bit extended run-time configuration byte, a flag that selects four-byte addressing, and a 2-bit upper-address segment register. The command engine hands it one strobe for each opcode it decodes, a copy of its write-enable latch, and the data bytes that follow a write opcode. The block reports the current register values back to the engine.

The block also carries out the two-opcode software reset. An arming opcode must come directly before the reset opcode. When the reset happens, the run-time registers, the addressing flag and the segment register are rebuilt from fields of the persistent word, and a one-cycle pulse tells the engine to drop its own transient state: its write-enable latch, its current address and its command state. The rebuild from the persistent word applies only when the part's manufacturer code equals a chosen value. For other parts the reset only clears the addressing flag and the segment register.

The persistent word is never changed by a reset. It comes out of hardware reset at a parameter default and can be rewritten only by a write sequence while writes are enabled.

Top module: `cfgreg_reset_unit`

## Requirements
- R1: Opcode 0x66 arms the software reset. Opcode 0x99 resets only when the opcode strobed just before it was 0x66. Any other opcode disarms, and a reset also disarms, so 0x99 repeated on its own does nothing. 0x66 repeated stays armed.
- R2: After a software reset, run-time config bits 1:0 are both 1, and bits 7:4 equal persistent bits 15:12.
- R3: After a software reset, run-time config bit 3 is 1 unless persistent bits 11:9 are all 1, in which case it is 0.
- R4: After a software reset, extended config bits 2:0 are 7, bits 3 and 4 are 1, bit 5 is 0, bit 6 copies persistent bit 2 and bit 7 copies persistent bit 3.
- R5: After a software reset, four-byte addressing is on exactly when persistent bit 0 is 0. The segment register becomes 3 when persistent bit 1 is 0, and 0 otherwise.
- R6: After hardware reset, the persistent word is 0x8FFF and the other registers hold the values R2 to R5 derive from it: run-time 0x83, extended 0xDF, four-byte addressing off, segment 0.
- R7: A software reset drives `soft_reset` high for exactly the one cycle after the clock edge that took the 0x99 opcode. It leaves the persistent word unchanged.
- R8: Opcode 0xB1 with write enable set, followed by two data bytes (low byte first), replaces the persistent word at the edge that takes the second byte. The first byte alone changes nothing.
- R9: Opcode 0x81 (run-time) or 0x61 (extended), with write enable set and followed by one data byte, loads that byte into the register.
- R10: A write opcode given while write enable is clear is ignored, and so are the data bytes that follow it.
- R11: Opcode 0xB7 turns four-byte addressing on and 0xE9 turns it off, from the next cycle.
- R12: Any opcode strobed before a write's last byte abandons that write. Data bytes that arrive with no write pending are ignored.
- R13: With a manufacturer code other than the derive code (default 0x20), hardware reset gives run-time and extended values of 0. A software reset leaves them as they were and clears four-byte addressing and the segment register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| op_valid | input | 1 | A decoded opcode is present this cycle |
| op_code | input | 8 | Opcode value qualified by op_valid |
| wr_enable | input | 1 | Command engine write-enable latch, sampled with a write opcode |
| byte_valid | input | 1 | A data byte following an opcode is present |
| byte_data | input | 8 | Data byte qualified by byte_valid |
| nv_cfg | output | 16 | Persistent configuration word |
| v_cfg | output | 8 | Run-time configuration byte |
| ev_cfg | output | 8 | Extended run-time configuration byte |
| addr4_mode | output | 1 | Four-byte addressing selected |
| ext_addr | output | 2 | Upper address segment |
| soft_reset | output | 1 | One-cycle pulse after a software reset |

## Verification
Every register result is due at the clock edge that samples its opcode or its final data byte, so it can be seen one cycle after the stimulus is driven. The soft-reset pulse is high only during the cycle that follows the edge that took the reset opcode. The bench drives inputs on falling edges and checks the pulse at the falling edge right after the opcode edge. It queues each expected register set, which a monitor compares just after the next rising edge. No input is active during that edge, so the value being checked is settled and cannot be overwritten by the next command.

// File: rtl/cfgrst_pkg.sv
package cfgrst_pkg;

   localparam logic [7:0] OPC_RST_ARM  = 8'h66;
   localparam logic [7:0] OPC_RST_FIRE = 8'h99;
   localparam logic [7:0] OPC_A4_ON    = 8'hB7;
   localparam logic [7:0] OPC_A4_OFF   = 8'hE9;
   localparam logic [7:0] OPC_WR_NV    = 8'hB1;
   localparam logic [7:0] OPC_WR_VOL   = 8'h81;
   localparam logic [7:0] OPC_WR_ENH   = 8'h61;

   typedef enum logic [2:0] {
      CLS_OTHER,
      CLS_ARM,
      CLS_FIRE,
      CLS_A4_ON,
      CLS_A4_OFF,
      CLS_WR_NV,
      CLS_WR_VOL,
      CLS_WR_ENH
   } op_cls_e;

   // run-time byte rebuilt from the persistent word
   function automatic logic [7:0] boot_vol(input logic [15:0] nv);
      logic [7:0] r;
      r      = 8'h03;
      r[7:4] = nv[15:12];
      r[3]   = (nv[11:9] != 3'b111);
      return r;
   endfunction

   // extended byte rebuilt from the persistent word
   function automatic logic [7:0] boot_enh(input logic [15:0] nv);
      logic [7:0] r;
      r    = 8'h1F;
      r[6] = nv[2];
      r[7] = nv[3];
      return r;
   endfunction

endpackage

// File: rtl/cfgrst_decode.sv
module cfgrst_decode
   import cfgrst_pkg::*;
(
   input  logic [7:0] op_code,
   output op_cls_e    op_cls,
   output logic       op_is_write
);

   always_comb begin
      unique case (op_code)
         OPC_RST_ARM:  op_cls = CLS_ARM;
         OPC_RST_FIRE: op_cls = CLS_FIRE;
         OPC_A4_ON:    op_cls = CLS_A4_ON;
         OPC_A4_OFF:   op_cls = CLS_A4_OFF;
         OPC_WR_NV:    op_cls = CLS_WR_NV;
         OPC_WR_VOL:   op_cls = CLS_WR_VOL;
         OPC_WR_ENH:   op_cls = CLS_WR_ENH;
         default:      op_cls = CLS_OTHER;
      endcase
   end

   assign op_is_write = (op_cls == CLS_WR_NV) || (op_cls == CLS_WR_VOL) ||
                        (op_cls == CLS_WR_ENH);

endmodule

// File: rtl/cfgrst_arm.sv
module cfgrst_arm
   import cfgrst_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    op_valid,
   input  op_cls_e op_cls,
   output logic    fire
);

   logic armed_q;

   // the reset opcode acts only right after the arming opcode
   assign fire = op_valid && (op_cls == CLS_FIRE) && armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (op_valid) begin
         armed_q <= (op_cls == CLS_ARM);
      end
   end

endmodule

// File: rtl/cfgrst_collect.sv
module cfgrst_collect #(
   parameter int BYTE_W = 8,
   parameter int SLOTS  = 2,
   localparam int CW    = $clog2(SLOTS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [CW-1:0]            need,
   input  logic                     cancel,
   input  logic                     byte_valid,
   input  logic [BYTE_W-1:0]        byte_data,
   output logic                     done,
   output logic [SLOTS*BYTE_W-1:0]  word
);

   logic          active_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] need_q;
   logic          take;

   assign take = active_q && byte_valid && !cancel;
   assign done = take && (cnt_q == need_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         need_q   <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
         need_q   <= need;
      end else if (cancel) begin
         active_q <= 1'b0;
      end else if (take) begin
         cnt_q <= cnt_q + 1'b1;
         if (done) active_q <= 1'b0;
      end
   end

   // slot 0 holds the first (least significant) byte
   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [BYTE_W-1:0] slot_q;
      logic              hit;
      assign hit = take && (cnt_q == CW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   slot_q <= '0;
         else if (hit) slot_q <= byte_data;
      end
      assign word[i*BYTE_W +: BYTE_W] = hit ? byte_data : slot_q;
   end

endmodule

// File: rtl/cfgrst_derive.sv
module cfgrst_derive
   import cfgrst_pkg::*;
#(
   parameter bit DERIVE_EN = 1'b1,
   parameter int EXT_W     = 2
) (
   input  logic [15:0]      nv,
   output logic [7:0]       vol_new,
   output logic [7:0]       enh_new,
   output logic             a4_new,
   output logic [EXT_W-1:0] ext_new
);

   if (DERIVE_EN) begin : g_derive
      assign vol_new = boot_vol(nv);
      assign enh_new = boot_enh(nv);
      assign a4_new  = !nv[0];
      assign ext_new = nv[1] ? '0 : EXT_W'(3);
   end else begin : g_plain
      assign vol_new = '0;
      assign enh_new = '0;
      assign a4_new  = 1'b0;
      assign ext_new = '0;
   end

endmodule

// File: rtl/cfgreg_reset_unit.sv
module cfgreg_reset_unit
   import cfgrst_pkg::*;
#(
   parameter int                          BYTE_W     = 8,
   parameter int                          NV_BYTES   = 2,
   parameter int                          EXT_W      = 2,
   parameter logic [7:0]                  MFR_ID     = 8'h20,
   parameter logic [7:0]                  DERIVE_MFR = 8'h20,
   parameter logic [NV_BYTES*BYTE_W-1:0]  NV_DEFAULT = 16'h8FFF
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       op_valid,
   input  logic [7:0]                 op_code,
   input  logic                       wr_enable,
   input  logic                       byte_valid,
   input  logic [BYTE_W-1:0]          byte_data,
   output logic [NV_BYTES*BYTE_W-1:0] nv_cfg,
   output logic [BYTE_W-1:0]          v_cfg,
   output logic [BYTE_W-1:0]          ev_cfg,
   output logic                       addr4_mode,
   output logic [EXT_W-1:0]           ext_addr,
   output logic                       soft_reset
);

   localparam int NV_W      = NV_BYTES * BYTE_W;
   localparam int CW        = $clog2(NV_BYTES + 1);
   localparam bit DERIVE_EN = (MFR_ID == DERIVE_MFR);

   localparam logic [7:0]       V_RST   = DERIVE_EN ? boot_vol(NV_DEFAULT[15:0]) : 8'h00;
   localparam logic [7:0]       EV_RST  = DERIVE_EN ? boot_enh(NV_DEFAULT[15:0]) : 8'h00;
   localparam logic             A4_RST  = DERIVE_EN && !NV_DEFAULT[0];
   localparam logic [EXT_W-1:0] EXT_RST = (DERIVE_EN && !NV_DEFAULT[1]) ? EXT_W'(3) : '0;

   if (BYTE_W != 8) begin : g_bad_byte
      $error("cfgreg_reset_unit: BYTE_W must be 8");
   end
   if (NV_BYTES < 2) begin : g_bad_nv
      $error("cfgreg_reset_unit: NV_BYTES must be at least 2");
   end
   if (EXT_W < 2) begin : g_bad_ext
      $error("cfgreg_reset_unit: EXT_W must be at least 2");
   end

   op_cls_e             op_cls;
   logic                op_is_write;
   logic                fire;
   logic                wr_start;
   logic                wr_done;
   logic [CW-1:0]       wr_need;
   logic [NV_W-1:0]     wr_word;
   op_cls_e             tgt_q;
   logic [7:0]          d_vol;
   logic [7:0]          d_enh;
   logic                d_a4;
   logic [EXT_W-1:0]    d_ext;

   logic [NV_W-1:0]     nv_q;
   logic [BYTE_W-1:0]   v_q;
   logic [BYTE_W-1:0]   ev_q;
   logic                a4_q;
   logic [EXT_W-1:0]    ext_q;
   logic                pulse_q;

   cfgrst_decode u_decode (
      .op_code     (op_code),
      .op_cls      (op_cls),
      .op_is_write (op_is_write)
   );

   cfgrst_arm u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .op_cls   (op_cls),
      .fire     (fire)
   );

   assign wr_start = op_valid && op_is_write && wr_enable;
   assign wr_need  = (op_cls == CLS_WR_NV) ? CW'(NV_BYTES) : CW'(1);

   cfgrst_collect #(
      .BYTE_W (BYTE_W),
      .SLOTS  (NV_BYTES)
   ) u_collect (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (wr_start),
      .need       (wr_need),
      .cancel     (op_valid),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .done       (wr_done),
      .word       (wr_word)
   );

   cfgrst_derive #(
      .DERIVE_EN (DERIVE_EN),
      .EXT_W     (EXT_W)
   ) u_derive (
      .nv      (nv_q[15:0]),
      .vol_new (d_vol),
      .enh_new (d_enh),
      .a4_new  (d_a4),
      .ext_new (d_ext)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q <= CLS_OTHER;
      end else if (wr_start) begin
         tgt_q <= op_cls;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv_q    <= NV_DEFAULT;
         v_q     <= V_RST;
         ev_q    <= EV_RST;
         a4_q    <= A4_RST;
         ext_q   <= EXT_RST;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= fire;
         if (fire) begin
            if (DERIVE_EN) begin
               v_q  <= d_vol;
               ev_q <= d_enh;
            end
            a4_q  <= d_a4;
            ext_q <= d_ext;
         end else if (op_valid && op_cls == CLS_A4_ON) begin
            a4_q <= 1'b1;
         end else if (op_valid && op_cls == CLS_A4_OFF) begin
            a4_q <= 1'b0;
         end else if (wr_done) begin
            unique case (tgt_q)
               CLS_WR_NV:  nv_q <= wr_word;
               CLS_WR_VOL: v_q  <= wr_word[BYTE_W-1:0];
               CLS_WR_ENH: ev_q <= wr_word[BYTE_W-1:0];
               default:    ;
            endcase
         end
      end
   end

   assign nv_cfg     = nv_q;
   assign v_cfg      = v_q;
   assign ev_cfg     = ev_q;
   assign addr4_mode = a4_q;
   assign ext_addr   = ext_q;
   assign soft_reset = pulse_q;

endmodule

// File: rtl/cfgreg_reset_chk.sv
module cfgreg_reset_chk #(
   parameter bit DERIVE_EN = 1'b1,
   parameter int NV_W      = 16,
   parameter int EXT_W     = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [7:0]       op_code,
   input logic             byte_valid,
   input logic [NV_W-1:0]  nv_cfg,
   input logic [7:0]       v_cfg,
   input logic [7:0]       ev_cfg,
   input logic             addr4_mode,
   input logic [EXT_W-1:0] ext_addr,
   input logic             soft_reset
);

   AST_FIRE_FOLLOWS_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_reset |-> $past(op_valid && op_code == 8'h99)); // R1

   AST_RESET_VOL_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_reset && DERIVE_EN) |-> (v_cfg[1:0] == 2'b11 && v_cfg[7:4] == nv_cfg[15:12])); // R2

   AST_RESET_VOL_BIT3: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_reset && DERIVE_EN) |-> (v_cfg[3] == (nv_cfg[11:9] != 3'b111))); // R3

   AST_RESET_ENH_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_reset && DERIVE_EN) |-> (ev_cfg[5:0] == 6'h1F && ev_cfg[6] == nv_cfg[2] &&
                                     ev_cfg[7] == nv_cfg[3])); // R4

   AST_RESET_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
      soft_reset |-> (ext_addr == ((DERIVE_EN && !nv_cfg[1]) ? EXT_W'(3) : EXT_W'(0)))); // R5

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_reset |=> !soft_reset); // R7

   AST_NV_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_valid |=> $stable(nv_cfg)); // R8

   AST_ADDR4_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 8'hB7) |=> addr4_mode); // R11

   AST_ADDR4_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 8'hE9) |=> !addr4_mode); // R11

endmodule

bind cfgreg_reset_unit cfgreg_reset_chk #(
   .DERIVE_EN (DERIVE_EN),
   .NV_W      (NV_W),
   .EXT_W     (EXT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .op_code    (op_code),
   .byte_valid (byte_valid),
   .nv_cfg     (nv_cfg),
   .v_cfg      (v_cfg),
   .ev_cfg     (ev_cfg),
   .addr4_mode (addr4_mode),
   .ext_addr   (ext_addr),
   .soft_reset (soft_reset)
);

// File: tb/cfgreg_reset_unit_bench.sv
module cfgreg_reset_unit_bench;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] op_code = 8'h00;
   logic [7:0] byte_data = 8'h00;
   logic       wren = 1'b0;
   logic       opv_a = 1'b0, opv_b = 1'b0;
   logic       bv_a = 1'b0, bv_b = 1'b0;

   logic [15:0] nv_a, nv_b;
   logic [7:0]  v_a, v_b, ev_a, ev_b;
   logic        a4_a, a4_b, sr_a, sr_b;
   logic [1:0]  ext_a, ext_b;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfgreg_reset_unit u_cfgreg_reset_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(opv_a), .op_code(op_code),
      .wr_enable(wren), .byte_valid(bv_a), .byte_data(byte_data),
      .nv_cfg(nv_a), .v_cfg(v_a), .ev_cfg(ev_a), .addr4_mode(a4_a),
      .ext_addr(ext_a), .soft_reset(sr_a)
   );

   cfgreg_reset_unit #(.MFR_ID(8'hEF)) u_cfgreg_reset_unit_b (
      .clk(clk), .rst_n(rst_n), .op_valid(opv_b), .op_code(op_code),
      .wr_enable(wren), .byte_valid(bv_b), .byte_data(byte_data),
      .nv_cfg(nv_b), .v_cfg(v_b), .ev_cfg(ev_b), .addr4_mode(a4_b),
      .ext_addr(ext_b), .soft_reset(sr_b)
   );

   typedef struct {
      int          sel;
      logic [15:0] nv;
      logic [7:0]  v;
      logic [7:0]  ev;
      logic        a4;
      logic [1:0]  ext;
      string       tag;
   } exp_t;

   exp_t sb_q[$];

   task automatic check_val(input string tag, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // monitor: compares queued expectations just after an idle rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.sel == 0) begin
               check_val(e.tag, "nv_cfg", 32'(nv_a), 32'(e.nv));
               check_val(e.tag, "v_cfg", 32'(v_a), 32'(e.v));
               check_val(e.tag, "ev_cfg", 32'(ev_a), 32'(e.ev));
               check_val(e.tag, "addr4_mode", 32'(a4_a), 32'(e.a4));
               check_val(e.tag, "ext_addr", 32'(ext_a), 32'(e.ext));
            end else begin
               check_val(e.tag, "nv_cfg", 32'(nv_b), 32'(e.nv));
               check_val(e.tag, "v_cfg", 32'(v_b), 32'(e.v));
               check_val(e.tag, "ev_cfg", 32'(ev_b), 32'(e.ev));
               check_val(e.tag, "addr4_mode", 32'(a4_b), 32'(e.a4));
               check_val(e.tag, "ext_addr", 32'(ext_b), 32'(e.ext));
            end
         end
      end
   end

   task automatic expect_st(input int sel, input logic [15:0] nv, input logic [7:0] v,
                            input logic [7:0] ev, input logic a4, input logic [1:0] ext,
                            input string tag);
      exp_t e;
      e.sel = sel; e.nv = nv; e.v = v; e.ev = ev; e.a4 = a4; e.ext = ext; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic op(input int sel, input logic [7:0] c);
      @(negedge clk);
      op_code = c;
      opv_a = (sel == 0);
      opv_b = (sel == 1);
      @(negedge clk);
      opv_a = 1'b0;
      opv_b = 1'b0;
   endtask

   task automatic byt(input int sel, input logic [7:0] d);
      @(negedge clk);
      byte_data = d;
      bv_a = (sel == 0);
      bv_b = (sel == 1);
      @(negedge clk);
      bv_a = 1'b0;
      bv_b = 1'b0;
   endtask

   task automatic chk_pulse(input int sel, input logic exp, input string tag);
      check_val(tag, "soft_reset", 32'(sel == 0 ? sr_a : sr_b), 32'(exp));
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R6 and R13: hardware reset values
      expect_st(0, 16'h8FFF, 8'h83, 8'hDF, 1'b0, 2'd0, "R6");
      expect_st(1, 16'h8FFF, 8'h00, 8'h00, 1'b0, 2'd0, "R13");
      chk_pulse(0, 1'b0, "R7");

      // R11: address mode opcodes
      op(0, 8'hB7);
      expect_st(0, 16'h8FFF, 8'h83, 8'hDF, 1'b1, 2'd0, "R11");
      op(0, 8'hE9);
      expect_st(0, 16'h8FFF, 8'h83, 8'hDF, 1'b0, 2'd0, "R11");

      // R10: writes without write enable
      wren = 1'b0;
      op(0, 8'hB1); byt(0, 8'h00); byt(0, 8'h00);
      op(0, 8'h81); byt(0, 8'h00);
      expect_st(0, 16'h8FFF, 8'h83, 8'hDF, 1'b0, 2'd0, "R10");

      // R8: persistent write, low byte first
      wren = 1'b1;
      op(0, 8'hB1); byt(0, 8'h3C);
      expect_st(0, 16'h8FFF, 8'h83, 8'hDF, 1'b0, 2'd0, "R8");
      byt(0, 8'h51);
      expect_st(0, 16'h513C, 8'h83, 8'hDF, 1'b0, 2'd0, "R8");

      // R2 R3 R4 R5 R7: software reset from 0x513C
      op(0, 8'h66); op(0, 8'h99);
      chk_pulse(0, 1'b1, "R7");
      expect_st(0, 16'h513C, 8'h5B, 8'hDF, 1'b1, 2'd3, "R2 R3 R4 R5");
      @(negedge clk);
      chk_pulse(0, 1'b0, "R7");

      // R9: single-byte registers
      op(0, 8'h81); byt(0, 8'h12);
      op(0, 8'h61); byt(0, 8'h34);
      expect_st(0, 16'h513C, 8'h12, 8'h34, 1'b1, 2'd3, "R9");

      // R1: intervening opcode disarms
      op(0, 8'hE9);
      op(0, 8'h66); op(0, 8'h05); op(0, 8'h99);
      chk_pulse(0, 1'b0, "R1");
      expect_st(0, 16'h513C, 8'h12, 8'h34, 1'b0, 2'd3, "R1");

      // R1: repeated arm stays armed
      op(0, 8'h66); op(0, 8'h66); op(0, 8'h99);
      chk_pulse(0, 1'b1, "R1");
      expect_st(0, 16'h513C, 8'h5B, 8'hDF, 1'b1, 2'd3, "R1");

      // R1: lone reset opcode after a reset does nothing
      op(0, 8'h81); byt(0, 8'h12);
      op(0, 8'h99);
      chk_pulse(0, 1'b0, "R1");
      expect_st(0, 16'h513C, 8'h12, 8'hDF, 1'b1, 2'd3, "R1");

      // R12: abandoned write and stray byte
      op(0, 8'hB1); byt(0, 8'hAA); op(0, 8'h05); byt(0, 8'hBB);
      expect_st(0, 16'h513C, 8'h12, 8'hDF, 1'b1, 2'd3, "R12");

      // R3 R5: other branch of the derivation (0x0E03)
      op(0, 8'hB1); byt(0, 8'h03); byt(0, 8'h0E);
      expect_st(0, 16'h0E03, 8'h12, 8'hDF, 1'b1, 2'd3, "R8");
      op(0, 8'h66); op(0, 8'h99);
      expect_st(0, 16'h0E03, 8'h03, 8'h1F, 1'b0, 2'd0, "R3 R5");

      // R13: part without derivation keeps run-time values
      op(1, 8'h81); byt(1, 8'h77);
      op(1, 8'hB7);
      expect_st(1, 16'h8FFF, 8'h77, 8'h00, 1'b1, 2'd0, "R13");
      op(1, 8'h66); op(1, 8'h99);
      chk_pulse(1, 1'b1, "R13");
      expect_st(1, 16'h8FFF, 8'h77, 8'h00, 1'b0, 2'd0, "R13");

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule